// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

This block is a 32-pin general-purpose I/O controller. It sits on a simple synchronous register bus with address, write data, write strobe, read strobe and registered read data. The pins are grouped into two banks of sixteen. Address bit 7 selects the bank, and both banks share one 256-byte decode window.

Each bank holds eight per-pin configuration registers. These are output level, drive enable, open-drain mode, two auxiliary-function selects, pull-up, pull-down and input enable. The bank also has a read-only pin-level register. Every configuration write is a set/clear word: a one in the low half sets the matching pin's bit and a one in the high half clears it. Software can therefore change single pins without a read-modify-write sequence, and separate agents cannot disturb each other's pins.

The pad side carries output level, drive enable, pull controls and auxiliary selects. Open-drain mode is folded into the drive enable. Pad inputs pass through a synchronizer and are masked by input enable before they reach the level register.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every configuration register reads 0, and padOut, padOe, padPullUp, padPullDn, padAux1 and padAux2 are all 0.
- R2: A configuration write sets pin n's bit when wdata bit n (n = 0..15) is 1, and clears it when wdata bit n+16 is 1. A pin with both bits 0 keeps its value. The new value is visible on the pad outputs in the cycle after the write edge.
- R3: When a write has both the set bit and the clear bit of a pin at 1, the pin's bit ends at 0.
- R4: Address bit 7 selects the bank. Offsets 0x00–0x7F address pins 0–15 and 0x80–0xFF address pins 16–31. A write to one bank leaves the other bank unchanged.
- R5: The in-bank offsets are 0x00 output level (padOut), 0x04 drive enable, 0x08 open-drain, 0x10 auxiliary select 1 (padAux1), 0x14 auxiliary select 2 (padAux2), 0x18 pull-up (padPullUp), 0x1C pull-down (padPullDn) and 0x20 input enable.
- R6: padOe for a pin is 1 only when its drive enable is 1 and it is not the case that open-drain and output level are both 1.
- R7: Offset 0x30 returns the bank's pad levels after a two-flop synchronizer, ANDed with input enable. A pin change reaches the register two edges after it is applied, and a pin with input enable 0 reads 0.
- R8: Writes to offset 0x30 change no register and no pad output.
- R9: A read presented with busRead at a clock edge shows on busRdata after that edge and holds until the next read. The data carries the 16 pin bits in [15:0] and zeros in [31:16].
- R10: An unmapped offset, or any offset that is not word aligned, reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address within the 256-byte window |
| busWdata | input | 32 | Set/clear write word |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Pad output level |
| padOe | output | 32 | Pad drive enable |
| padPullUp | output | 32 | Pull-up control |
| padPullDn | output | 32 | Pull-down control |
| padAux1 | output | 32 | Auxiliary function select 1 |
| padAux2 | output | 32 | Auxiliary function select 2 |

## Verification
The bench builds the block with its default parameters: two banks of sixteen pins, a 32-bit data bus, an 8-bit address and two synchronizer stages. With these values both banks and the full 256-byte window, including the high-bank mirror of every offset, are reachable from the bench. The two-edge input latency is also short enough to check exactly against a behavioural model on every cycle. Directed sequences cover the set-versus-clear conflict, the open-drain drive gating and the masking of inputs by input enable. Random traffic over mapped, unmapped and misaligned addresses then drives both the model and the design.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // register slot indices inside one bank's configuration array
  localparam int IDX_OUT  = 0;
  localparam int IDX_OE   = 1;
  localparam int IDX_OD   = 2;
  localparam int IDX_AUX1 = 3;
  localparam int IDX_AUX2 = 4;
  localparam int IDX_PU   = 5;
  localparam int IDX_PD   = 6;
  localparam int IDX_IE   = 7;
  localparam int NUM_CFG  = 8;

  typedef enum logic [3:0] {
    SEL_OUT  = 4'd0,
    SEL_OE   = 4'd1,
    SEL_OD   = 4'd2,
    SEL_AUX1 = 4'd3,
    SEL_AUX2 = 4'd4,
    SEL_PU   = 4'd5,
    SEL_PD   = 4'd6,
    SEL_IE   = 4'd7,
    SEL_RB   = 4'd8,
    SEL_NONE = 4'd9
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrStb;
    logic    rdStb;
    logic    bankSel;
    regSel_e sel;
  } busCmd_t;

  function automatic regSel_e decodeOffset(input logic [6:0] off);
    regSel_e s;
    case (off)
      7'h00:   s = SEL_OUT;
      7'h04:   s = SEL_OE;
      7'h08:   s = SEL_OD;
      7'h10:   s = SEL_AUX1;
      7'h14:   s = SEL_AUX2;
      7'h18:   s = SEL_PU;
      7'h1C:   s = SEL_PD;
      7'h20:   s = SEL_IE;
      7'h30:   s = SEL_RB;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output busCmd_t           cmd
);
  localparam int OFF_W = ADDR_W - 1;

  regSel_e selDec;
  logic    isCfg;

  always_comb begin
    selDec = decodeOffset(busAddr[OFF_W-1:0]);
    // configuration slots only; level register and holes never write (R8, R10)
    isCfg  = (selDec != SEL_RB) && (selDec != SEL_NONE);
    cmd.bankSel = busAddr[ADDR_W-1];
    cmd.sel     = selDec;
    cmd.wrStb   = busWrite && isCfg;
    cmd.rdStb   = busRead;
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int BANK_PINS   = 16,
  parameter int NUM_BANKS   = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busCmd_t              cmd,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [PINS-1:0]      padIn,
  output logic [DATA_W-1:0]    rdata,
  output logic [PINS-1:0]      padOut,
  output logic [PINS-1:0]      padOe,
  output logic [PINS-1:0]      padPullUp,
  output logic [PINS-1:0]      padPullDn,
  output logic [PINS-1:0]      padAux1,
  output logic [PINS-1:0]      padAux2
);
  localparam int PINS   = BANK_PINS * NUM_BANKS;
  localparam int HIGH_W = DATA_W - BANK_PINS;

  logic [BANK_PINS-1:0] cfgQ  [NUM_BANKS][NUM_CFG];
  logic [BANK_PINS-1:0] rbVal [NUM_BANKS];
  logic [PINS-1:0]      syncQ [SYNC_STAGES];
  logic [BANK_PINS-1:0] setMask, clrMask, rdNext;

  assign setMask = wdata[BANK_PINS-1:0];
  assign clrMask = wdata[2*BANK_PINS-1:BANK_PINS];

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
      logic hit;
      assign hit = cmd.wrStb && (cmd.bankSel == 1'(b)) && (cmd.sel == regSel_e'(c));
      // clear has priority over set
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)    cfgQ[b][c] <= '0;
        else if (hit) cfgQ[b][c] <= (cfgQ[b][c] | setMask) & ~clrMask;
      end
    end

    assign rbVal[b] = syncQ[SYNC_STAGES-1][b*BANK_PINS +: BANK_PINS] & cfgQ[b][IDX_IE];

    assign padOut   [b*BANK_PINS +: BANK_PINS] = cfgQ[b][IDX_OUT];
    assign padOe    [b*BANK_PINS +: BANK_PINS] =
      cfgQ[b][IDX_OE] & ~(cfgQ[b][IDX_OD] & cfgQ[b][IDX_OUT]);
    assign padPullUp[b*BANK_PINS +: BANK_PINS] = cfgQ[b][IDX_PU];
    assign padPullDn[b*BANK_PINS +: BANK_PINS] = cfgQ[b][IDX_PD];
    assign padAux1  [b*BANK_PINS +: BANK_PINS] = cfgQ[b][IDX_AUX1];
    assign padAux2  [b*BANK_PINS +: BANK_PINS] = cfgQ[b][IDX_AUX2];
  end

  // read source selection
  always_comb begin
    rdNext = '0;
    for (int c = 0; c < NUM_CFG; c++) begin
      if (cmd.sel == regSel_e'(c)) rdNext = cfgQ[cmd.bankSel][c];
    end
    if (cmd.sel == SEL_RB) rdNext = rbVal[cmd.bankSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (cmd.rdStb) rdata <= {{HIGH_W{1'b0}}, rdNext};
  end

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_bank_pkg::*;
#(
  parameter int BANK_PINS   = 16,
  parameter int NUM_BANKS   = 2,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = BANK_PINS * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWrite,
  input  logic              busRead,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padPullUp,
  output logic [PINS-1:0]   padPullDn,
  output logic [PINS-1:0]   padAux1,
  output logic [PINS-1:0]   padAux2
);
  busCmd_t cmd;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .busRead (busRead),
    .cmd     (cmd)
  );

  gpio_bank_dp #(
    .BANK_PINS  (BANK_PINS),
    .NUM_BANKS  (NUM_BANKS),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .wdata    (busWdata),
    .padIn    (padIn),
    .rdata    (busRdata),
    .padOut   (padOut),
    .padOe    (padOe),
    .padPullUp(padPullUp),
    .padPullDn(padPullDn),
    .padAux1  (padAux1),
    .padAux2  (padAux2)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PINS   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWrite,
  input logic              busRead,
  input logic [DATA_W-1:0] busRdata,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   padPullUp,
  input logic [PINS-1:0]   padPullDn,
  input logic [PINS-1:0]   padAux1,
  input logic [PINS-1:0]   padAux2
);
  logic lowOutWr, highOutWr, rbWr, holeWr, lowOeWr;
  assign lowOutWr  = busWrite && busAddr == 8'h00;
  assign highOutWr = busWrite && busAddr == 8'h80;
  assign lowOeWr   = busWrite && busAddr == 8'h04;
  assign rbWr      = busWrite && (busAddr == 8'h30 || busAddr == 8'hB0);
  assign holeWr    = busWrite && (busAddr == 8'h0C || busAddr == 8'h24 || busAddr == 8'h01);

  // R2 and R3: set/clear word applied to low-bank output levels
  a_r2_setclr_low: assert property (@(posedge clk) disable iff (!rstN)
    lowOutWr |=> padOut[15:0] ==
      (($past(padOut[15:0]) | $past(busWdata[15:0])) & ~$past(busWdata[31:16])));

  // R4: high-bank write updates pins 16..31 and leaves the low bank alone
  a_r4_bank_high: assert property (@(posedge clk) disable iff (!rstN)
    highOutWr |=> (padOut[31:16] ==
      (($past(padOut[31:16]) | $past(busWdata[15:0])) & ~$past(busWdata[31:16])))
      && $stable(padOut[15:0]));

  // R6: clearing drive enable removes pad drive
  a_r6_oe_clear: assert property (@(posedge clk) disable iff (!rstN)
    lowOeWr |=> (padOe[15:0] & $past(busWdata[31:16])) == 16'h0);

  // R8: writes to the level register touch nothing
  a_r8_rb_write: assert property (@(posedge clk) disable iff (!rstN)
    rbWr |=> $stable(padOut) && $stable(padOe) && $stable(padPullUp)
             && $stable(padPullDn) && $stable(padAux1) && $stable(padAux2));

  // R10: writes to holes or misaligned addresses touch nothing
  a_r10_hole_write: assert property (@(posedge clk) disable iff (!rstN)
    holeWr |=> $stable(padOut) && $stable(padOe) && $stable(padPullUp)
               && $stable(padPullDn) && $stable(padAux1) && $stable(padAux2));

  // R9: upper half of read data is always zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRead |=> busRdata[31:16] == 16'h0);

endmodule

bind gpio_setclr_bank gpio_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PINS(PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busWrite (busWrite),
  .busRead  (busRead),
  .busRdata (busRdata),
  .padOut   (padOut),
  .padOe    (padOe),
  .padPullUp(padPullUp),
  .padPullDn(padPullDn),
  .padAux1  (padAux1),
  .padAux2  (padAux2)
);

// File: tb/gpio_setclr_bank_test.sv
module gpio_setclr_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe, padPullUp, padPullDn, padAux1, padAux2;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr_bank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .busRead(busRead), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp), .padPullDn(padPullDn),
    .padAux1(padAux1), .padAux2(padAux2)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] mCfg [2][8];
  logic [31:0] mS1, mS2, mRd;

  function automatic int slotOf(input logic [6:0] off);
    case (off)
      7'h00: return 0;  7'h04: return 1;  7'h08: return 2;  7'h10: return 3;
      7'h14: return 4;  7'h18: return 5;  7'h1C: return 6;  7'h20: return 7;
      7'h30: return 8;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++) for (int c = 0; c < 8; c++) mCfg[b][c] = '0;
      mS1 = '0; mS2 = '0; mRd = '0;
    end else begin
      int bk, sl;
      bk = busAddr[7];
      sl = slotOf(busAddr[6:0]);
      if (busRead) begin
        if (sl >= 0 && sl < 8) mRd = {16'h0, mCfg[bk][sl]};
        else if (sl == 8)      mRd = {16'h0, mS2[bk*16 +: 16] & mCfg[bk][7]};
        else                   mRd = '0;
      end
      if (busWrite && sl >= 0 && sl < 8)
        mCfg[bk][sl] = (mCfg[bk][sl] | busWdata[15:0]) & ~busWdata[31:16];
      mS2 = mS1;
      mS1 = padIn;
    end
  end

  function automatic logic [31:0] mPad(input int slot);
    logic [31:0] v;
    for (int b = 0; b < 2; b++) begin
      if (slot == 1) v[b*16 +: 16] = mCfg[b][1] & ~(mCfg[b][2] & mCfg[b][0]);
      else           v[b*16 +: 16] = mCfg[b][slot];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    chk("R5 padOut",    padOut,    mPad(0));
    chk("R6 padOe",     padOe,     mPad(1));
    chk("R5 padAux1",   padAux1,   mPad(3));
    chk("R5 padAux2",   padAux2,   mPad(4));
    chk("R5 padPullUp", padPullUp, mPad(5));
    chk("R5 padPullDn", padPullDn, mPad(6));
    chk("R9 busRdata",  busRdata,  mRd);
  endtask

  task automatic cyc(input logic [7:0] a, input logic [31:0] w, input bit we, input bit re);
    @(negedge clk);
    if (cmpOn) compareModel();
    busAddr = a; busWdata = w; busWrite = we; busRead = re;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] w);
    cyc(a, w, 1'b1, 1'b0);
    cyc(8'h00, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic rdExpect(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cyc(a, 32'h0, 1'b0, 1'b1);
    cyc(8'h00, 32'h0, 1'b0, 1'b0);
    chk(tag, busRdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 padOut", padOut, 32'h0);
    chk("R1 padOe", padOe, 32'h0);
    chk("R1 pulls", padPullUp | padPullDn, 32'h0);
    chk("R1 aux", padAux1 | padAux2, 32'h0);
    cmpOn = 1'b1;
    rdExpect(8'h20, 32'h0, "R1 ie reset");
    rdExpect(8'h84, 32'h0, "R1 oe high reset");

    // R2 set, clear, no-op
    wr(8'h00, 32'h0000_00A5);
    chk("R2 set", padOut, 32'h0000_00A5);
    rdExpect(8'h00, 32'h0000_00A5, "R9 read out");
    wr(8'h00, 32'h0001_0000);
    chk("R2 clear", padOut, 32'h0000_00A4);
    wr(8'h00, 32'h0000_0000);
    chk("R2 unchanged", padOut, 32'h0000_00A4);

    // R3 clear wins
    wr(8'h00, 32'h0004_0004);
    chk("R3 clear priority", padOut, 32'h0000_00A0);

    // R4 high bank
    wr(8'h80, 32'h0000_8001);
    chk("R4 high bank", padOut, 32'h8001_00A0);

    // R6 drive gating with open drain
    wr(8'h04, 32'h0000_00FF);
    chk("R6 oe plain", padOe, 32'h0000_00FF);
    wr(8'h08, 32'h0000_00F0);
    chk("R6 od gating", padOe, 32'h0000_005F);

    // R5 remaining slots
    wr(8'h10, 32'h0000_0003);
    wr(8'h94, 32'h0000_0300);
    wr(8'h18, 32'h0000_1000);
    wr(8'h9C, 32'h0000_0040);
    chk("R5 aux1", padAux1, 32'h0000_0003);
    chk("R5 aux2", padAux2, 32'h0300_0000);
    chk("R5 pullup", padPullUp, 32'h0000_1000);
    chk("R5 pulldn", padPullDn, 32'h0040_0000);

    // R7 level register through synchronizer and input enable
    wr(8'h20, 32'h0000_FFFF);
    wr(8'hA0, 32'h0000_00FF);
    padIn = 32'h1234_ABCD;
    repeat (3) cyc(8'h00, 32'h0, 1'b0, 1'b0);
    rdExpect(8'h30, 32'h0000_ABCD, "R7 low level");
    rdExpect(8'hB0, 32'h0000_0034, "R7 high gated");
    wr(8'h20, 32'h000F_0000);
    rdExpect(8'h30, 32'h0000_ABC0, "R7 ie off reads 0");

    // R8 writes to level register
    wr(8'h30, 32'hFFFF_FFFF);
    chk("R8 out untouched", padOut, 32'h8001_00A0);
    rdExpect(8'h30, 32'h0000_ABC0, "R8 level unchanged");

    // R10 holes and misaligned addresses
    wr(8'h0C, 32'h0000_FFFF);
    wr(8'h01, 32'h0000_FFFF);
    wr(8'h24, 32'h0000_FFFF);
    chk("R10 out untouched", padOut, 32'h8001_00A0);
    chk("R10 oe untouched", padOe, 32'h0000_005F);
    rdExpect(8'h0C, 32'h0, "R10 hole reads 0");
    rdExpect(8'h01, 32'h0, "R10 misaligned reads 0");

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      a = {$urandom_range(0, 1) == 1, 7'($urandom_range(0, 15) * 4)};
      if ($urandom_range(0, 9) == 0) a = a | 8'h02;
      if ($urandom_range(0, 7) == 0) padIn = $urandom;
      cyc(a, $urandom, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    cyc(8'h00, 32'h0, 1'b0, 1'b0);
    cyc(8'h00, 32'h0, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule